// File: doc/BRIEF.md
# Branch Trail Stack

This block keeps a short history of the taken branches a core retires. Each record is a pair of 64-bit words, one with the source address and one with the target address. The newest record always reads back at logical entry 0, and older records appear at entries 1, 2 and so on. New records do not move any stored data. Instead a top-of-stack pointer steps backwards through a ring of physical slots, and every read or write index is mapped through that pointer.

Recording is controlled by several inputs. A nine-bit select register suppresses classes of branch: a set bit means that class is never recorded. A global enable input must be high. An optional freeze mode stops recording while a performance-monitoring interrupt is pending. Software reads and writes each word through an indexed register port. The usual way to empty the stack is to write zero to every word and clear the select register.

Top module: `branch_trail`

## Requirements
- R1: After reset every word reads zero, so every entry has {valid, spec} = 00, and the select register reads zero.
- R2: A recorded branch appears at logical entry 0 on the clock after it retires. The entry that was at logical index i moves to index i+1. Register address 2*i returns the from word of entry i and address 2*i+1 returns its to word.
- R3: The from word holds the source address in bits 57:0, five copies of source bit 57 in bits 62:58, and the mispredict flag in bit 63.
- R4: The to word holds the target address in bits 57:0, three copies of target bit 57 in bits 60:58, zero in bit 61, and the retire status code {valid, spec} in bits 63:62.
- R5: A retire is not recorded if its status code is 00 (codes: 01 wrong-path speculative, 10 non-speculative, 11 correct-path speculative) or if its kind is 7 (no branch).
- R6: Select bit 0 suppresses branches whose privilege input is 0. Select bit 1 suppresses branches whose privilege input is nonzero.
- R7: Select bits 2 to 8 suppress the branch kinds 0 to 6 respectively: 0 conditional, 1 near relative call, 2 near indirect call, 3 near return, 4 near indirect jump, 5 near relative jump, 6 far branch.
- R8: When all DEPTH entries are in use, a new record replaces the oldest one. The other entries keep their order.
- R9: Nothing is recorded while the enable input is low.
- R10: Nothing is recorded while both freeze mode and the pending-interrupt input are high. A pending interrupt has no effect when freeze mode is low.
- R11: A register write changes the addressed word on the next clock and does not move the top-of-stack pointer. Writing zero to both words of an entry empties that entry.
- R12: If a branch is recorded in the same cycle as a register write, the branch is recorded and the write is dropped.
- R13: The select register takes the low nine bits of its write data on the clock after its write strobe and reads them back on sel_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| br_valid_i | input | 1 | A branch retires this cycle |
| br_from_i | input | 58 | Branch source address |
| br_to_i | input | 58 | Branch target address |
| br_priv_i | input | 2 | Privilege level at the target (0 is most privileged) |
| br_kind_i | input | 3 | Branch kind, encoded as in R7; 7 means no branch |
| br_mispred_i | input | 1 | The branch was mispredicted |
| br_status_i | input | 2 | Retire status code {valid, spec} |
| enable_i | input | 1 | Global recording enable |
| freeze_en_i | input | 1 | Freeze recording while an interrupt is pending |
| pmi_pending_i | input | 1 | Performance-monitoring interrupt pending |
| sel_we_i | input | 1 | Select register write strobe |
| sel_wdata_i | input | 9 | Select register write data |
| sel_o | output | 9 | Select register value |
| reg_we_i | input | 1 | Word write strobe |
| reg_addr_i | input | $clog2(2*DEPTH) | Word index: 2*entry for the from word, 2*entry+1 for the to word |
| reg_wdata_i | input | 64 | Word write data |
| reg_rdata_o | output | 64 | Word at reg_addr_i (combinational) |

## Verification
Directed retires check the bit packing of each word using source and target addresses with bit 57 both clear and set. Each select bit is set alone in turn, and the same stimulus is then repeated with the bit clear. This separates a wrong class-to-bit mapping from an all-or-nothing filter. More retires than DEPTH are sent so the ring wraps, which shows whether the oldest entry is replaced and the order is kept. A write is placed in the same cycle as a retire to show which one wins. After that, random kinds, privilege levels, status codes, enable and freeze settings run under random select masks. The full word array is compared against a queue model, so a single misplaced or missing record shows up at its logical index.

// File: rtl/branch_trail_pkg.sv
package branch_trail_pkg;
  localparam int ADDR_W = 58;
  localparam int WORD_W = 64;
  localparam int SEL_W  = 9;

  typedef enum logic [2:0] {
    BK_COND     = 3'd0,
    BK_CALL_REL = 3'd1,
    BK_CALL_IND = 3'd2,
    BK_RET      = 3'd3,
    BK_JMP_IND  = 3'd4,
    BK_JMP_REL  = 3'd5,
    BK_FAR      = 3'd6,
    BK_NONE     = 3'd7
  } br_kind_e;

  function automatic logic [WORD_W-1:0] pack_from(input logic [ADDR_W-1:0] a, input logic mis);
    return {mis, {5{a[ADDR_W-1]}}, a};
  endfunction

  function automatic logic [WORD_W-1:0] pack_to(input logic [ADDR_W-1:0] a, input logic [1:0] code);
    return {code, 1'b0, {3{a[ADDR_W-1]}}, a};
  endfunction
endpackage

// File: rtl/bt_filter.sv
module bt_filter
  import branch_trail_pkg::*;
(
  input  logic             valid_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [1:0]       priv_i,
  input  logic [2:0]       kind_i,
  input  logic [1:0]       status_i,
  input  logic             enable_i,
  input  logic             freeze_en_i,
  input  logic             pmi_i,
  output logic             take_o
);
  logic [SEL_W-1:0] hit;

  always_comb begin
    hit    = '0;
    hit[0] = (priv_i == 2'd0);
    hit[1] = (priv_i != 2'd0);
    if (kind_i != BK_NONE) hit[{1'b0, kind_i} + 4'd2] = 1'b1;
  end

  assign take_o = valid_i && enable_i && !(freeze_en_i && pmi_i) &&
                  (status_i != 2'b00) && (kind_i != BK_NONE) &&
                  ((hit & sel_i) == '0);
endmodule

// File: rtl/bt_ring.sv
module bt_ring
  import branch_trail_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int RW   = PW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [WORD_W-1:0] push_from_i,
  input  logic [WORD_W-1:0] push_to_i,
  input  logic              wr_i,
  input  logic [RW-1:0]     addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [PW-1:0]     tos_o
);
  logic [WORD_W-1:0] from_q [DEPTH];
  logic [WORD_W-1:0] to_q   [DEPTH];
  logic [PW-1:0]     tos_q, tos_dec, phys;

  assign tos_dec = tos_q - 1'b1;
  // logical entry -> physical slot through the renaming pointer
  assign phys    = tos_q + addr_i[RW-1:1];
  assign rdata_o = addr_i[0] ? to_q[phys] : from_q[phys];
  assign tos_o   = tos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tos_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        from_q[i] <= '0;
        to_q[i]   <= '0;
      end
    end else if (push_i) begin
      tos_q           <= tos_dec;
      from_q[tos_dec] <= push_from_i;
      to_q[tos_dec]   <= push_to_i;
    end else if (wr_i) begin
      if (addr_i[0]) to_q[phys]   <= wdata_i;
      else           from_q[phys] <= wdata_i;
    end
  end
endmodule

// File: rtl/branch_trail.sv
module branch_trail
  import branch_trail_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int RW   = PW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              br_valid_i,
  input  logic [ADDR_W-1:0] br_from_i,
  input  logic [ADDR_W-1:0] br_to_i,
  input  logic [1:0]        br_priv_i,
  input  logic [2:0]        br_kind_i,
  input  logic              br_mispred_i,
  input  logic [1:0]        br_status_i,
  input  logic              enable_i,
  input  logic              freeze_en_i,
  input  logic              pmi_pending_i,
  input  logic              sel_we_i,
  input  logic [SEL_W-1:0]  sel_wdata_i,
  output logic [SEL_W-1:0]  sel_o,
  input  logic              reg_we_i,
  input  logic [RW-1:0]     reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o
);
  logic [SEL_W-1:0] sel_q;
  logic             take;
  logic [PW-1:0]    tos;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= '0;
    else if (sel_we_i) sel_q <= sel_wdata_i;
  end
  assign sel_o = sel_q;

  bt_filter u_filter (
    .valid_i    (br_valid_i),
    .sel_i      (sel_q),
    .priv_i     (br_priv_i),
    .kind_i     (br_kind_i),
    .status_i   (br_status_i),
    .enable_i   (enable_i),
    .freeze_en_i(freeze_en_i),
    .pmi_i      (pmi_pending_i),
    .take_o     (take)
  );

  bt_ring #(.DEPTH(DEPTH)) u_ring (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (take),
    .push_from_i(pack_from(br_from_i, br_mispred_i)),
    .push_to_i  (pack_to(br_to_i, br_status_i)),
    .wr_i       (reg_we_i && !take),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .tos_o      (tos)
  );
endmodule

module branch_trail_chk #(
  parameter int PW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          take_i,
  input logic [PW-1:0] tos_i,
  input logic [8:0]    sel_i,
  input logic [1:0]    priv_i,
  input logic [2:0]    kind_i,
  input logic [1:0]    status_i,
  input logic          enable_i,
  input logic          freeze_en_i,
  input logic          pmi_i
);
  AST_PUSH_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> tos_i == $past(tos_i) - 1'b1); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(tos_i)); // R11
  AST_EMPTY_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == 2'b00 || kind_i == 3'd7) |-> !take_i); // R5
  AST_SUPPRESS_PRIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> !(priv_i == 2'd0 ? sel_i[0] : sel_i[1])); // R6
  AST_SUPPRESS_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && kind_i != 3'd7) |-> !sel_i[{1'b0, kind_i} + 4'd2]); // R7
  AST_ENABLE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !take_i); // R9
  AST_FREEZE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_en_i && pmi_i) |-> !take_i); // R10
endmodule

bind branch_trail branch_trail_chk #(.PW(PW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .take_i     (take),
  .tos_i      (tos),
  .sel_i      (sel_q),
  .priv_i     (br_priv_i),
  .kind_i     (br_kind_i),
  .status_i   (br_status_i),
  .enable_i   (enable_i),
  .freeze_en_i(freeze_en_i),
  .pmi_i      (pmi_pending_i)
);

// File: tb/branch_trail_tb.sv
module branch_trail_tb;
  localparam int DEPTH = 16;
  localparam int RW    = $clog2(2*DEPTH);

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        br_valid_i = 0, br_mispred_i = 0;
  logic [57:0] br_from_i = '0, br_to_i = '0;
  logic [1:0]  br_priv_i = '0, br_status_i = '0;
  logic [2:0]  br_kind_i = '0;
  logic        enable_i = 1, freeze_en_i = 0, pmi_pending_i = 0;
  logic        sel_we_i = 0, reg_we_i = 0;
  logic [8:0]  sel_wdata_i = '0, sel_o;
  logic [RW-1:0] reg_addr_i = '0;
  logic [63:0] reg_wdata_i = '0, reg_rdata_o;

  int errors = 0, checks = 0;
  logic [63:0] mf [DEPTH];
  logic [63:0] mt [DEPTH];
  logic [8:0]  msel = '0;

  always #10 clk_i = ~clk_i;

  branch_trail #(.DEPTH(DEPTH)) u_dut (.*);

  task automatic tick(); @(posedge clk_i); #1; endtask

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_word(string req, int a);
    reg_addr_i = RW'(a); #1;
    chk(req, reg_rdata_o, a[0] ? mt[a/2] : mf[a/2]);
  endtask

  task automatic chk_all(string req);
    for (int a = 0; a < 2*DEPTH; a++) chk_word(req, a);
  endtask

  function automatic bit predict(logic [1:0] priv, logic [2:0] kind, logic [1:0] st);
    if (!enable_i || (freeze_en_i && pmi_pending_i)) return 0;
    if (st == 2'b00 || kind == 3'd7) return 0;
    if (priv == 0 && msel[0]) return 0;
    if (priv != 0 && msel[1]) return 0;
    if (msel[kind + 2]) return 0;
    return 1;
  endfunction

  function automatic logic [63:0] mk_from(logic [57:0] a, logic m);
    logic [63:0] w = {6'b0, a};
    for (int b = 58; b < 63; b++) w[b] = a[57];
    w[63] = m;
    return w;
  endfunction

  function automatic logic [63:0] mk_to(logic [57:0] a, logic [1:0] st);
    logic [63:0] w = {6'b0, a};
    for (int b = 58; b < 61; b++) w[b] = a[57];
    w[63] = st[1]; w[62] = st[0];
    return w;
  endfunction

  task automatic model_push(logic [63:0] f, logic [63:0] t);
    for (int i = DEPTH-1; i > 0; i--) begin mf[i] = mf[i-1]; mt[i] = mt[i-1]; end
    mf[0] = f; mt[0] = t;
  endtask

  task automatic set_sel(logic [8:0] v);
    sel_we_i = 1; sel_wdata_i = v; tick(); sel_we_i = 0; msel = v;
  endtask

  task automatic retire(logic [57:0] f, logic [57:0] t, logic [1:0] pv, logic [2:0] k,
                        logic m, logic [1:0] st);
    bit p;
    br_valid_i = 1; br_from_i = f; br_to_i = t; br_priv_i = pv; br_kind_i = k;
    br_mispred_i = m; br_status_i = st;
    p = predict(pv, k, st);
    tick();
    br_valid_i = 0;
    if (p) model_push(mk_from(f, m), mk_to(t, st));
  endtask

  task automatic reg_write(int a, logic [63:0] d);
    reg_we_i = 1; reg_addr_i = RW'(a); reg_wdata_i = d; tick(); reg_we_i = 0;
    if (a[0]) mt[a/2] = d; else mf[a/2] = d;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mf[i] = '0; mt[i] = '0; end
    void'($urandom(32'd1234));
    #45 rst_ni = 1; tick();

    // R1 reset state
    chk_all("R1");
    chk("R1 sel", {55'b0, sel_o}, 64'h0);

    // R13 select register
    set_sel(9'h1ff); chk("R13", {55'b0, sel_o}, 64'h1ff);
    set_sel(9'h0a5); chk("R13", {55'b0, sel_o}, 64'h0a5);
    set_sel(9'h000);

    // R3 / R4 packing, negative and positive addresses
    retire(58'h2000000_0000_1234, 58'h3ff_ffff_ffff_0008, 2'd3, 3'd0, 1'b1, 2'b10);
    reg_addr_i = 0; #1; chk("R3", reg_rdata_o, {1'b1, 5'h1f, 58'h2000000_0000_1234});
    reg_addr_i = 1; #1; chk("R4", reg_rdata_o, {2'b10, 1'b0, 3'h7, 58'h3ff_ffff_ffff_0008});
    retire(58'h0000_0000_0400, 58'h0000_0000_0800, 2'd0, 3'd3, 1'b0, 2'b01);
    reg_addr_i = 0; #1; chk("R3", reg_rdata_o, {1'b0, 5'h00, 58'h0000_0000_0400});
    reg_addr_i = 1; #1; chk("R4", reg_rdata_o, {2'b01, 1'b0, 3'h0, 58'h0000_0000_0800});
    reg_addr_i = 2; #1; chk("R2 order", reg_rdata_o, {1'b1, 5'h1f, 58'h2000000_0000_1234});

    // R5 empty status or no-branch kind
    retire(58'h11, 58'h22, 2'd1, 3'd2, 1'b0, 2'b00);
    retire(58'h33, 58'h44, 2'd1, 3'd7, 1'b0, 2'b11);
    chk_all("R5");

    // R6 privilege suppression
    set_sel(9'h001);
    retire(58'h55, 58'h66, 2'd0, 3'd1, 1'b0, 2'b11);
    chk_word("R6", 0);
    retire(58'h77, 58'h88, 2'd2, 3'd1, 1'b0, 2'b11);
    chk_word("R6", 0);
    set_sel(9'h002);
    retire(58'h99, 58'haa, 2'd1, 3'd1, 1'b0, 2'b11);
    retire(58'hbb, 58'hcc, 2'd0, 3'd1, 1'b0, 2'b11);
    chk_all("R6");

    // R7 one class bit at a time
    for (int k = 0; k < 7; k++) begin
      set_sel(9'(1 << (k + 2)));
      retire(58'(100 + k), 58'(200 + k), 2'd1, 3'(k), 1'b0, 2'b10);
      retire(58'(300 + k), 58'(400 + k), 2'd1, 3'((k + 1) % 7), 1'b1, 2'b10);
      chk_word("R7", 0);
      chk_word("R7", 3);
    end
    set_sel(9'h000);
    chk_all("R7");

    // R9 enable
    enable_i = 0;
    retire(58'h501, 58'h502, 2'd1, 3'd5, 1'b0, 2'b10);
    chk_all("R9");
    enable_i = 1;

    // R10 freeze
    freeze_en_i = 1; pmi_pending_i = 1;
    retire(58'h601, 58'h602, 2'd1, 3'd5, 1'b0, 2'b10);
    chk_all("R10");
    freeze_en_i = 0;
    retire(58'h603, 58'h604, 2'd1, 3'd5, 1'b0, 2'b10);
    chk_all("R10");
    pmi_pending_i = 0;

    // R8 wrap beyond depth
    for (int i = 0; i < DEPTH + 5; i++)
      retire(58'(32'h1000 + i), 58'(32'h2000 + i), 2'(i % 4), 3'(i % 7), 1'(i % 2), 2'(1 + i % 3));
    chk_all("R8");

    // R11 register writes
    reg_write(7, 64'hdead_beef_0123_4567);
    chk_word("R11", 7);
    for (int a = 0; a < 2*DEPTH; a++) reg_write(a, 64'h0);
    set_sel(9'h000);
    chk_all("R11");

    // R12 collision: retire wins, write dropped
    retire(58'h701, 58'h702, 2'd1, 3'd0, 1'b0, 2'b11);
    reg_we_i = 1; reg_addr_i = 0; reg_wdata_i = 64'hffff_0000_ffff_0000;
    br_valid_i = 1; br_from_i = 58'h703; br_to_i = 58'h704; br_priv_i = 1;
    br_kind_i = 3'd1; br_mispred_i = 0; br_status_i = 2'b11;
    tick();
    reg_we_i = 0; br_valid_i = 0;
    model_push(mk_from(58'h703, 0), mk_to(58'h704, 2'b11));
    chk_all("R12");

    // random phase
    for (int n = 0; n < 400; n++) begin
      if (n % 25 == 0) set_sel(9'($urandom) & 9'h1ff & ~9'h003 | 9'($urandom_range(0, 2) == 0 ? 1 : 0));
      enable_i      = ($urandom_range(0, 9) != 0);
      freeze_en_i   = $urandom_range(0, 1);
      pmi_pending_i = ($urandom_range(0, 3) == 0);
      retire({$urandom, $urandom} & 58'h3ff_ffff_ffff_ffff, {$urandom, $urandom} & 58'h3ff_ffff_ffff_ffff,
             2'($urandom), 3'($urandom), 1'($urandom), 2'($urandom));
      chk_word("R2", 0);
      chk_word("R2", 1);
      if (n % 50 == 49) chk_all("R2");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule